// File: doc/BRIEF.md
# Shadow-Stack Access Policy Filter

This block sits in the execute path in front of the load/store unit and decides, for every memory-class operation, whether it may go on. Operations that belong to the shadow-stack family (push, pop-and-check, pointer read, word swap, doubleword swap) are legal only when the shadow-stack enable for the current privilege level is set. Beyond that, the atomic swap is refused in machine mode, and any shadow-stack operation below machine mode is refused while address translation and protection is off. A page-type rule then applies to every operation. Shadow-stack operations may touch only pages whose shadow-stack attribute is set, and ordinary loads, stores and atomics may touch only pages whose attribute is clear. The page attribute arrives as an input from the translation logic.

Accepted operations enter a single registered stage. A legal operation leaves that stage on the load/store stream, tagged as shadow-stack or ordinary. A refused operation leaves it as a one-cycle fault report to the scoreboard, carrying the cause, the virtual address and the transaction ID. It never reaches the load/store stream. The input and load/store sides are valid/ready streams. The input is taken when `in_valid` and `in_ready` are both high at a clock edge. A legal item is handed over when `lsu_valid` and `lsu_ready` are both high. While the stage holds a legal item that has not been taken, its payload stays fixed and `in_ready` stays low. The fault report has no back-pressure, so a fault leaves the stage in the cycle after it enters and never waits on `lsu_ready`.

Top module: `sstk_gate`

## Requirements
- R1: Operation codes are 0 load, 1 store, 2 ordinary atomic, 3 shadow push, 4 shadow pop-and-check, 5 shadow pointer read, 6 shadow swap word, 7 shadow swap doubleword. Privilege codes are 0 user, 1 supervisor, 2 hypervisor, 3 machine. The enable for the current level is `en_m` in machine mode, `en_h` in hypervisor mode, and `en_s` in supervisor and user mode. A shadow-stack operation (code 3 to 7) with that enable clear is refused with cause 2 (illegal instruction).
- R2: With the enable set, a shadow swap (code 6 or 7) in machine mode is refused with cause 7 (store access fault).
- R3: With the enable set, a shadow-stack operation below machine mode while `xlate_on` is low is refused with cause 7. In machine mode, `xlate_on` has no effect on this rule.
- R4: A shadow-stack operation other than pointer read that targets a page with `in_page_ss` low is refused with cause 7.
- R5: An ordinary operation (code 0 to 2) that targets a page with `in_page_ss` high is refused with cause 7, whatever the enables are.
- R6: The pointer read (code 5) is exempt from the page-type rule and passes on either page type when its other checks hold.
- R7: An operation that passes every check appears on the load/store stream with its code, address and ID unchanged, and with `lsu_ss` high for codes 3 to 7 and low for codes 0 to 2.
- R8: A refused operation never appears on the load/store stream. It raises `flt_valid` for exactly one cycle, with its cause, address and ID on the fault outputs.
- R9: An operation accepted at a clock edge is visible on its output, either the load/store stream or the fault port, right after that edge (one cycle of latency).
- R10: While `lsu_valid` is high and `lsu_ready` is low, the load/store payload holds and `in_ready` is low. A fault is reported without waiting for `lsu_ready`.
- R11: The illegal-instruction cause wins over every store access fault rule.
- R12: After reset, `lsu_valid` and `flt_valid` are low and `in_ready` is high.
- R13: The enables of privilege levels other than the current one have no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv | input | 2 | Current privilege level (0 U, 1 S, 2 H, 3 M) |
| xlate_on | input | 1 | Supervisor/virtual translation and protection active |
| en_m | input | 1 | Shadow-stack enable, machine configuration |
| en_s | input | 1 | Shadow-stack enable, supervisor configuration (governs S and U) |
| en_h | input | 1 | Shadow-stack enable, hypervisor configuration |
| in_valid | input | 1 | Input operation valid |
| in_ready | output | 1 | Filter can take an operation |
| in_op | input | 3 | Operation code |
| in_vaddr | input | VA_W | Virtual address of the access |
| in_tid | input | TID_W | Transaction ID |
| in_page_ss | input | 1 | Target page carries the shadow-stack attribute |
| lsu_valid | output | 1 | Legal operation offered to the load/store unit |
| lsu_ready | input | 1 | Load/store unit takes the offered operation |
| lsu_op | output | 3 | Operation code |
| lsu_vaddr | output | VA_W | Virtual address |
| lsu_tid | output | TID_W | Transaction ID |
| lsu_ss | output | 1 | Operation is a shadow-stack operation |
| flt_valid | output | 1 | One-cycle fault report to the scoreboard |
| flt_cause | output | 4 | Fault cause (2 illegal instruction, 7 store access fault) |
| flt_vaddr | output | VA_W | Faulting virtual address |
| flt_tid | output | TID_W | Transaction ID of the faulting operation |

## Verification
Directed cases walk each refusal rule at its edge. Swap runs in machine mode against supervisor mode. Shadow operations run with translation off below and in machine mode. Pointer read and push run on both page types, and ordinary stores run on shadow pages with every enable cleared. Together these tell each rule from its neighbours and show that the illegal cause wins. Hypervisor-mode cases flip `en_h` against `en_s`, and supervisor cases clear the machine and hypervisor enables, which shows that the right enable is chosen and the others are ignored. A random stream of mixed operations with a random `lsu_ready` then exercises back-pressure. It shows that stalled payloads hold, that faults overtake no queued item and still appear one cycle after acceptance, and that results come out in input order.

// File: rtl/sstk_gate_pkg.sv
package sstk_gate_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_AMO   = 3'd2,
    OP_SPUSH = 3'd3,
    OP_SPOPC = 3'd4,
    OP_SRDP  = 3'd5,
    OP_SSWPW = 3'd6,
    OP_SSWPD = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    PRV_U = 2'd0,
    PRV_S = 2'd1,
    PRV_H = 2'd2,
    PRV_M = 2'd3
  } prv_e;

  localparam int OP_W    = 3;
  localparam int PRV_W   = 2;
  localparam int CAUSE_W = 4;

  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL   = 4'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_ST_ACCESS = 4'd7;

  // class flags derived from an operation code
  typedef struct packed {
    logic ss;    // shadow-stack family
    logic mem;   // touches memory
    logic swap;  // atomic shadow swap
  } opcls_t;

endpackage

// File: rtl/sstk_decode.sv
module sstk_decode
  import sstk_gate_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output opcls_t          cls
);

  always_comb begin
    cls = '{ss: 1'b0, mem: 1'b1, swap: 1'b0};
    unique case (op_e'(op))
      OP_LOAD, OP_STORE, OP_AMO: cls = '{ss: 1'b0, mem: 1'b1, swap: 1'b0};
      OP_SPUSH, OP_SPOPC:        cls = '{ss: 1'b1, mem: 1'b1, swap: 1'b0};
      OP_SRDP:                   cls = '{ss: 1'b1, mem: 1'b0, swap: 1'b0};
      OP_SSWPW, OP_SSWPD:        cls = '{ss: 1'b1, mem: 1'b1, swap: 1'b1};
      default:                   cls = '{ss: 1'b0, mem: 1'b1, swap: 1'b0};
    endcase
  end

endmodule

// File: rtl/sstk_policy.sv
module sstk_policy
  import sstk_gate_pkg::*;
(
  input  opcls_t               cls,
  input  logic [PRV_W-1:0]     priv,
  input  logic                 xlate_on,
  input  logic                 en_m,
  input  logic                 en_s,
  input  logic                 en_h,
  input  logic                 page_ss,
  output logic                 pass,
  output logic [CAUSE_W-1:0]   cause
);

  // rule index 0 has the highest priority
  localparam int NRULE = 5;
  localparam int R_ILL = 0;

  logic             lvl_en;
  logic             is_mach;
  logic [NRULE-1:0] viol;

  always_comb begin
    unique case (prv_e'(priv))
      PRV_M:   lvl_en = en_m;
      PRV_H:   lvl_en = en_h;
      default: lvl_en = en_s;
    endcase
  end

  assign is_mach = (prv_e'(priv) == PRV_M);

  always_comb begin
    viol[0] = cls.ss && !lvl_en;                  // disabled: illegal
    viol[1] = cls.swap && is_mach;                // swap in machine mode
    viol[2] = cls.ss && !is_mach && !xlate_on;    // no translation below M
    viol[3] = cls.ss && cls.mem && !page_ss;      // shadow op on normal page
    viol[4] = !cls.ss && page_ss;                 // ordinary op on shadow page
  end

  always_comb begin
    pass  = 1'b1;
    cause = CAUSE_ST_ACCESS;
    for (int i = NRULE - 1; i >= 0; i--) begin
      if (viol[i]) begin
        pass  = 1'b0;
        cause = (i == R_ILL) ? CAUSE_ILLEGAL : CAUSE_ST_ACCESS;
      end
    end
  end

endmodule

// File: rtl/sstk_stage.sv
module sstk_stage
  import sstk_gate_pkg::*;
#(
  parameter int VA_W  = 39,
  parameter int TID_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [OP_W-1:0]    in_op,
  input  logic [VA_W-1:0]    in_vaddr,
  input  logic [TID_W-1:0]   in_tid,
  input  logic               in_ss,
  input  logic               in_pass,
  input  logic [CAUSE_W-1:0] in_cause,
  output logic               lsu_valid,
  input  logic               lsu_ready,
  output logic [OP_W-1:0]    lsu_op,
  output logic [VA_W-1:0]    lsu_vaddr,
  output logic [TID_W-1:0]   lsu_tid,
  output logic               lsu_ss,
  output logic               flt_valid,
  output logic [CAUSE_W-1:0] flt_cause,
  output logic [VA_W-1:0]    flt_vaddr,
  output logic [TID_W-1:0]   flt_tid
);

  logic               stg_v;
  logic               stg_flt;
  logic [OP_W-1:0]    stg_op;
  logic [VA_W-1:0]    stg_va;
  logic [TID_W-1:0]   stg_tid;
  logic               stg_ss;
  logic [CAUSE_W-1:0] stg_cause;
  logic               take;
  logic               drain;

  // a fault always leaves after one cycle; a legal item waits for lsu_ready
  assign drain    = stg_v && (stg_flt || lsu_ready);
  assign in_ready = !stg_v || drain;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_v   <= 1'b0;
      stg_flt <= 1'b0;
    end else if (take) begin
      stg_v   <= 1'b1;
      stg_flt <= !in_pass;
    end else if (drain) begin
      stg_v   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      stg_op    <= in_op;
      stg_va    <= in_vaddr;
      stg_tid   <= in_tid;
      stg_ss    <= in_ss;
      stg_cause <= in_cause;
    end
  end

  assign lsu_valid = stg_v && !stg_flt;
  assign lsu_op    = stg_op;
  assign lsu_vaddr = stg_va;
  assign lsu_tid   = stg_tid;
  assign lsu_ss    = stg_ss;

  assign flt_valid = stg_v && stg_flt;
  assign flt_cause = stg_cause;
  assign flt_vaddr = stg_va;
  assign flt_tid   = stg_tid;

endmodule

// File: rtl/sstk_gate.sv
module sstk_gate
  import sstk_gate_pkg::*;
#(
  parameter int VA_W  = 39,
  parameter int TID_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         priv,
  input  logic               xlate_on,
  input  logic               en_m,
  input  logic               en_s,
  input  logic               en_h,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [2:0]         in_op,
  input  logic [VA_W-1:0]    in_vaddr,
  input  logic [TID_W-1:0]   in_tid,
  input  logic               in_page_ss,
  output logic               lsu_valid,
  input  logic               lsu_ready,
  output logic [2:0]         lsu_op,
  output logic [VA_W-1:0]    lsu_vaddr,
  output logic [TID_W-1:0]   lsu_tid,
  output logic               lsu_ss,
  output logic               flt_valid,
  output logic [3:0]         flt_cause,
  output logic [VA_W-1:0]    flt_vaddr,
  output logic [TID_W-1:0]   flt_tid
);

  opcls_t             cls;
  logic               ok;
  logic [CAUSE_W-1:0] why;

  sstk_decode u_dec (
    .op  (in_op),
    .cls (cls)
  );

  sstk_policy u_pol (
    .cls      (cls),
    .priv     (priv),
    .xlate_on (xlate_on),
    .en_m     (en_m),
    .en_s     (en_s),
    .en_h     (en_h),
    .page_ss  (in_page_ss),
    .pass     (ok),
    .cause    (why)
  );

  sstk_stage #(.VA_W(VA_W), .TID_W(TID_W)) u_stg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_op     (in_op),
    .in_vaddr  (in_vaddr),
    .in_tid    (in_tid),
    .in_ss     (cls.ss),
    .in_pass   (ok),
    .in_cause  (why),
    .lsu_valid (lsu_valid),
    .lsu_ready (lsu_ready),
    .lsu_op    (lsu_op),
    .lsu_vaddr (lsu_vaddr),
    .lsu_tid   (lsu_tid),
    .lsu_ss    (lsu_ss),
    .flt_valid (flt_valid),
    .flt_cause (flt_cause),
    .flt_vaddr (flt_vaddr),
    .flt_tid   (flt_tid)
  );

endmodule

// File: rtl/sstk_gate_chk.sv
module sstk_gate_chk #(
  parameter int VA_W  = 39,
  parameter int TID_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       priv,
  input logic             xlate_on,
  input logic             en_m,
  input logic             en_s,
  input logic             en_h,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       in_op,
  input logic [VA_W-1:0]  in_vaddr,
  input logic [TID_W-1:0] in_tid,
  input logic             in_page_ss,
  input logic             lsu_valid,
  input logic             lsu_ready,
  input logic [2:0]       lsu_op,
  input logic [VA_W-1:0]  lsu_vaddr,
  input logic [TID_W-1:0] lsu_tid,
  input logic             lsu_ss,
  input logic             flt_valid,
  input logic [3:0]       flt_cause,
  input logic [VA_W-1:0]  flt_vaddr,
  input logic [TID_W-1:0] flt_tid
);

  logic acc;
  logic cur_en;
  logic is_ss;
  assign acc    = in_valid && in_ready;
  assign is_ss  = (in_op >= 3'd3);
  assign cur_en = (priv == 2'd3) ? en_m : (priv == 2'd2) ? en_h : en_s;

  assert_disabled_illegal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_ss && !cur_en |=> flt_valid && flt_cause == 4'd2);

  assert_swap_mach_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op == 3'd6 || in_op == 3'd7) && priv == 2'd3 && en_m
    |=> flt_valid && flt_cause == 4'd7);

  assert_no_xlate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_ss && cur_en && priv != 2'd3 && !xlate_on
    |=> flt_valid && flt_cause == 4'd7);

  assert_ord_on_ss_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !is_ss && in_page_ss |=> flt_valid && flt_cause == 4'd7);

  assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> lsu_valid || flt_valid);

  assert_id_carried_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (flt_valid ? flt_tid : lsu_tid) == $past(in_tid)
         && (flt_valid ? flt_vaddr : lsu_vaddr) == $past(in_vaddr));

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lsu_valid, flt_valid}));

  assert_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !flt_valid |=> lsu_valid |-> lsu_ss == ($past(in_op) >= 3'd3));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lsu_valid && !lsu_ready |=> lsu_valid && $stable(lsu_op) && $stable(lsu_vaddr)
                             && $stable(lsu_tid) && $stable(lsu_ss));

  assert_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lsu_valid && !lsu_ready |-> !in_ready);

endmodule

bind sstk_gate sstk_gate_chk #(.VA_W(VA_W), .TID_W(TID_W)) u_chk (.*);

// File: tb/sstk_gate_test.sv
module sstk_gate_test;

  localparam int VA_W  = 39;
  localparam int TID_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       priv = 2'd1;
  logic             xlate_on = 1'b1;
  logic             en_m = 1'b1, en_s = 1'b1, en_h = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [2:0]       in_op = 3'd0;
  logic [VA_W-1:0]  in_vaddr = '0;
  logic [TID_W-1:0] in_tid = '0;
  logic             in_page_ss = 1'b0;
  logic             lsu_valid;
  logic             lsu_ready = 1'b1;
  logic [2:0]       lsu_op;
  logic [VA_W-1:0]  lsu_vaddr;
  logic [TID_W-1:0] lsu_tid;
  logic             lsu_ss;
  logic             flt_valid;
  logic [3:0]       flt_cause;
  logic [VA_W-1:0]  flt_vaddr;
  logic [TID_W-1:0] flt_tid;

  sstk_gate #(.VA_W(VA_W), .TID_W(TID_W)) uut (.*);

  always #10 clk = ~clk;

  typedef struct {
    logic             pass;
    logic [3:0]       cause;
    logic [2:0]       op;
    logic [VA_W-1:0]  va;
    logic [TID_W-1:0] tid;
    int               acc;
    logic             lat_exact;
    string            req;
  } exp_t;

  exp_t exq[$];
  int   n_chk = 0, n_fail = 0, cyc = 0;
  logic stall_mode = 1'b0;
  logic done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // reference model written from the requirements
  function automatic logic [4:0] model(logic [2:0] op, logic [1:0] pv, logic x,
                                       logic em, logic es, logic eh, logic pg);
    logic ss, en;
    ss = (op >= 3);
    en = (pv == 3) ? em : (pv == 2) ? eh : es;
    if (ss && !en)                       return {1'b0, 4'd2};   // R1 R11
    if ((op == 6 || op == 7) && pv == 3) return {1'b0, 4'd7};   // R2
    if (ss && pv != 3 && !x)             return {1'b0, 4'd7};   // R3
    if (ss && op != 5 && !pg)            return {1'b0, 4'd7};   // R4 R6
    if (!ss && pg)                       return {1'b0, 4'd7};   // R5
    return {1'b1, 4'd0};
  endfunction

  task automatic check(logic ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: called just after a rising edge
  task automatic send(string req, logic [2:0] op, logic [1:0] pv, logic x,
                      logic em, logic es, logic eh, logic pg,
                      logic [VA_W-1:0] va, logic [TID_W-1:0] tid);
    exp_t e;
    logic [4:0] r;
    priv = pv; xlate_on = x; en_m = em; en_s = es; en_h = eh;
    in_op = op; in_page_ss = pg; in_vaddr = va; in_tid = tid; in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    r = model(op, pv, x, em, es, eh, pg);
    e.pass = r[4]; e.cause = r[3:0]; e.op = op; e.va = va; e.tid = tid;
    e.acc = cyc + 1; e.lat_exact = !r[4] || !stall_mode; e.req = req;
    exq.push_back(e);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // ready driver
  initial begin
    forever begin
      @(posedge clk); #1;
      lsu_ready = stall_mode ? ($urandom_range(0, 2) == 0) : 1'b1;
    end
  end

  // monitor
  logic             hold_f = 1'b0;
  logic [2:0]       h_op;
  logic [VA_W-1:0]  h_va;
  logic [TID_W-1:0] h_tid;
  logic             h_ss;

  initial begin
    exp_t e;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (hold_f) begin
        check(lsu_valid && lsu_op == h_op && lsu_vaddr == h_va && lsu_tid == h_tid
              && lsu_ss == h_ss, "R10", "stalled payload", {lsu_tid, lsu_op}, {h_tid, h_op});
        hold_f = 1'b0;
      end
      if (lsu_valid && !lsu_ready) begin
        check(!in_ready, "R10", "in_ready while stalled", in_ready, 0);
        hold_f = 1'b1; h_op = lsu_op; h_va = lsu_vaddr; h_tid = lsu_tid; h_ss = lsu_ss;
      end
      if (flt_valid) begin
        if (exq.size() == 0) check(1'b0, "R8", "unexpected fault", flt_tid, 0);
        else begin
          e = exq.pop_front();
          check(!e.pass, e.req, "fault on legal op", 1, 0);
          check(flt_cause == e.cause, e.req, "fault cause", flt_cause, e.cause);
          check(flt_tid == e.tid && flt_vaddr == e.va, "R8", "fault id/addr",
                flt_tid, e.tid);
          check(cyc == e.acc, "R9", "fault latency", cyc, e.acc);
        end
      end
      if (lsu_valid && lsu_ready) begin
        if (exq.size() == 0) check(1'b0, "R7", "unexpected lsu item", lsu_tid, 0);
        else begin
          e = exq.pop_front();
          check(e.pass, e.req, "refused op reached lsu", 0, 1);
          check(lsu_op == e.op && lsu_vaddr == e.va && lsu_tid == e.tid, "R7",
                "lsu payload", {lsu_tid, lsu_op}, {e.tid, e.op});
          check(lsu_ss == (e.op >= 3), "R7", "lsu_ss tag", lsu_ss, e.op >= 3);
          if (e.lat_exact) check(cyc == e.acc, "R9", "lsu latency", cyc, e.acc);
          else             check(cyc >= e.acc, "R9", "lsu latency", cyc, e.acc);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!lsu_valid && !flt_valid && in_ready, "R12", "reset outputs",
          {lsu_valid, flt_valid, in_ready}, 3'b001);
    @(posedge clk); #1; rst_n = 1'b1;
    @(posedge clk); #1;
    //    req    op pv x  em es eh pg va      tid
    send("R7",  0, 1, 1, 1, 1, 1, 0, 39'h1000, 4'h1);   // load passes
    send("R5",  1, 1, 1, 0, 0, 0, 1, 39'h2000, 4'h2);   // store on shadow page
    send("R5",  2, 3, 0, 1, 1, 1, 1, 39'h2008, 4'h3);   // amo on shadow page, M
    send("R7",  3, 1, 1, 0, 1, 0, 1, 39'h3000, 4'h4);   // push passes (R13)
    send("R4",  4, 1, 1, 1, 1, 1, 0, 39'h3008, 4'h5);   // popchk on normal page
    send("R4",  3, 0, 1, 1, 1, 1, 0, 39'h3010, 4'h6);   // push on normal page
    send("R6",  5, 1, 1, 1, 1, 1, 0, 39'h0,    4'h7);   // rdp on normal page
    send("R6",  5, 0, 1, 1, 1, 1, 1, 39'h8,    4'h8);   // rdp on shadow page
    send("R2",  6, 3, 1, 1, 0, 0, 1, 39'h4000, 4'h9);   // swap w in M
    send("R2",  7, 3, 0, 1, 1, 1, 1, 39'h4008, 4'hA);   // swap d in M
    send("R7",  7, 1, 1, 0, 1, 0, 1, 39'h4010, 4'hB);   // swap d in S passes
    send("R3",  3, 0, 0, 1, 1, 1, 1, 39'h5000, 4'hC);   // push U, no xlate
    send("R3",  4, 2, 0, 1, 1, 1, 1, 39'h5008, 4'hD);   // popchk H, no xlate
    send("R3",  3, 3, 0, 1, 0, 0, 1, 39'h5010, 4'hE);   // push M, no xlate passes
    send("R1",  3, 1, 1, 1, 0, 1, 1, 39'h6000, 4'hF);   // S enable clear
    send("R11", 6, 3, 1, 0, 1, 1, 0, 39'h6008, 4'h0);   // M swap, disabled
    send("R1",  5, 0, 0, 1, 0, 1, 0, 39'h6010, 4'h1);   // rdp U disabled
    send("R13", 4, 2, 1, 1, 1, 0, 1, 39'h7000, 4'h2);   // H uses en_h
    send("R13", 4, 2, 1, 0, 0, 1, 1, 39'h7008, 4'h3);   // H passes on en_h
    send("R13", 0, 1, 1, 0, 0, 0, 0, 39'h7010, 4'h4);   // enables irrelevant
    // random stream with back-pressure
    stall_mode = 1'b1;
    for (int i = 0; i < 400; i++) begin
      send("R10", 3'($urandom), 2'($urandom), 1'($urandom_range(0, 3) != 0),
           1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0),
           1'($urandom_range(0, 3) != 0), 1'($urandom), VA_W'($urandom), TID_W'(i));
    end
    stall_mode = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(exq.size() == 0, "R8", "outstanding items", exq.size(), 0);
    finish_run();
  end

endmodule